// File: doc/BRIEF.md
# Selectable Mark Density Shaper

This block sits after a parallel pseudorandom word source and lowers the probability of a one in each output bit. A balanced sequence has ones about half the time. ANDing two consecutive sequence bits drops that to a quarter, and ANDing three drops it to an eighth. A test pattern with a DC imbalance can be produced this way without touching the generator itself.

Each cycle the block takes an 18-bit vector. Bits 15..0 are the current word, and bits 17..16 are the two bits of the previous word that sit next to the current word in sequence order. Higher index means earlier in time, so bit 16 directly precedes bit 15. Output bit i is the AND of a window that starts at input bit i and runs upward for one, two or three bits. The length of the window comes from a 2-bit density select. For the unused window taps, an OR forces that AND input high. The shaped word is registered, and its valid flag is delayed by one clock to match.

Top module: `mark_shaper`

## Requirements
- R1: With density select 00 (density 1/2), output bit i equals input bit i for i = 0..15.
- R2: With density select 01 (density 1/4), output bit i equals input bit i AND input bit i+1.
- R3: With density select 10 (density 1/8), output bit i equals the AND of input bits i, i+1 and i+2.
- R4: Density select 11 gives the same output as select 10.
- R5: Input bits 16 and 17 are the carried-in previous-word bits. They enter only the windows of output bits 14 and 15. Bit 16 follows bit 15 in the window, and bit 17 follows bit 16.
- R6: A word presented with valid_i high appears on dout_o one clock later. valid_o is valid_i delayed by one clock.
- R7: In a cycle where valid_i is low, dout_o keeps its previous value, and the din_i and sel_i of that cycle have no effect.
- R8: While rst_ni is low, dout_o is 0 and valid_o is 0.
- R9: A long run of 2^15-1 sequence input is sliced into words, with the two most recent bits of each word carried into the next vector. Over that run, the ratio of ones at the output is within ±2% of 1/2, 1/4 or 1/8 for select 00, 01 or 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input vector valid |
| din_i | input | 18 | Current word in bits 15..0, carried-in previous bits in 17..16 |
| sel_i | input | 2 | Density select: 00 gives 1/2, 01 gives 1/4, 10 and 11 give 1/8 |
| valid_o | output | 1 | Output word valid |
| dout_o | output | 16 | Registered shaped word |

## Verification
A wrong window decode shows up on the next clock edge. Under a lower density, dout_o then has ones where the shifted input copies are zero, or ones are missing where all the window bits are one. Vectors with a single zero placed at the word edge and inside the word make this visible. A fault in the carried-in bits only touches output bits 14 and 15, so boundary patterns aim at those two bits. A fault in the hold path changes dout_o in the cycle after an invalid input. A subtler bias in the taps only shows as a density ratio off target over a long run.

// File: rtl/mark_pkg.sv
package mark_pkg;
  typedef enum logic [1:0] {
    DENS_HALF    = 2'b00,
    DENS_QUARTER = 2'b01,
    DENS_EIGHTH  = 2'b10,
    DENS_ALIAS   = 2'b11
  } dens_sel_e;
endpackage

// File: rtl/mark_decode.sv
module mark_decode #(
  parameter int EXT_W = 2,
  parameter int SEL_W = 2
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [EXT_W:1]   tap_en_o
);
  int level;
  always_comb begin
    level = (int'(sel_i) > EXT_W) ? EXT_W : int'(sel_i);
    for (int k = 1; k <= EXT_W; k++) tap_en_o[k] = (level >= k);
  end
endmodule

// File: rtl/mark_cell.sv
module mark_cell #(
  parameter int EXT_W = 2
) (
  input  logic [EXT_W:0] win_i,
  input  logic [EXT_W:1] tap_en_i,
  output logic           bit_o
);
  logic acc;
  always_comb begin
    acc = win_i[0];
    // disabled taps are forced high by the OR
    for (int k = 1; k <= EXT_W; k++) acc = acc & (win_i[k] | ~tap_en_i[k]);
    bit_o = acc;
  end
endmodule

// File: rtl/mark_shaper.sv
module mark_shaper #(
  parameter int WORD_W = 16,
  parameter int EXT_W  = 2,
  parameter int SEL_W  = 2,
  localparam int IN_W  = WORD_W + EXT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [IN_W-1:0]   din_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] dout_o
);
  logic [EXT_W:1]    tap_en;
  logic [WORD_W-1:0] shaped;

  mark_decode #(.EXT_W(EXT_W), .SEL_W(SEL_W)) u_dec (
    .sel_i   (sel_i),
    .tap_en_o(tap_en)
  );

  for (genvar i = 0; i < WORD_W; i++) begin : g_cell
    mark_cell #(.EXT_W(EXT_W)) u_cell (
      .win_i   (din_i[i+EXT_W:i]),
      .tap_en_i(tap_en),
      .bit_o   (shaped[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      dout_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) dout_o <= shaped;
    end
  end
endmodule

// File: rtl/mark_shaper_chk.sv
module mark_shaper_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [17:0] din_i,
  input logic [1:0]  sel_i,
  input logic        valid_o,
  input logic [15:0] dout_o
);
  a_r6_valid_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> $stable(dout_o));

  a_r1_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(valid_i) && $past(sel_i) == 2'b00) |-> dout_o == $past(din_i[15:0]));

  a_r2_pair_subset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(valid_i) && $past(sel_i) != 2'b00) |->
      ((dout_o & ~$past(din_i[15:0])) == 16'h0 && (dout_o & ~$past(din_i[16:1])) == 16'h0));

  a_r3_triple_subset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(valid_i) && $past(sel_i[1])) |-> (dout_o & ~$past(din_i[17:2])) == 16'h0);
endmodule

bind mark_shaper mark_shaper_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .din_i  (din_i),
  .sel_i  (sel_i),
  .valid_o(valid_o),
  .dout_o (dout_o)
);

// File: tb/mark_shaper_test.sv
module mark_shaper_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  localparam int NWORDS = 2048;

  // {sel[1:0], din[17:0], expected[15:0]}
  localparam logic [35:0] VEC [NVEC] = '{
    {2'b00, 18'h3A5A5, 16'hA5A5},  // R1
    {2'b00, 18'h05555, 16'h5555},  // R1
    {2'b01, 18'h3FFFF, 16'hFFFF},  // R2
    {2'b01, 18'h0FFFF, 16'h7FFF},  // R2 R5
    {2'b01, 18'h05555, 16'h0000},  // R2
    {2'b01, 18'h3FFF3, 16'hFFF1},  // R2
    {2'b10, 18'h1FFFF, 16'h7FFF},  // R3 R5
    {2'b10, 18'h0FFFF, 16'h3FFF},  // R3 R5
    {2'b10, 18'h3FFF3, 16'hFFF0},  // R3
    {2'b11, 18'h0FFFF, 16'h3FFF}   // R4
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [17:0] din_i = '0;
  logic [1:0]  sel_i = '0;
  logic        valid_o;
  logic [15:0] dout_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mark_shaper uut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .din_i  (din_i),
    .sel_i  (sel_i),
    .valid_o(valid_o),
    .dout_o (dout_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, result visible after next posedge, sample at the negedge after
  task automatic apply(input logic v, input logic [1:0] s, input logic [17:0] d);
    valid_i = v; sel_i = s; din_i = d;
    @(negedge clk_i);
  endtask

  task automatic density_run(input logic [1:0] s, input int exp_pm, input string req);
    logic [14:0] lfsr = 15'h0001;
    logic [15:0] w;
    logic [1:0]  prev = 2'b00;
    logic        b;
    int ones = 0;
    int bits = 0;
    for (int n = 0; n < NWORDS; n++) begin
      for (int j = 15; j >= 0; j--) begin
        b = lfsr[14] ^ lfsr[13];
        lfsr = {lfsr[13:0], b};
        w[j] = b;
      end
      apply(1'b1, s, {prev, w});
      prev = w[1:0];
      if (n > 0) begin
        ones += $countones(dout_o);
        bits += 16;
      end
    end
    valid_i = 1'b0;
    total++;
    if (ones * 1000 < bits * (exp_pm - 20) || ones * 1000 > bits * (exp_pm + 20)) begin
      bad++;
      $display("FAIL %s: actual=%0d/%0d ones expected=%0d permil", req, ones, bits, exp_pm);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R8 reset state
    apply(1'b1, 2'b00, 18'h3FFFF);
    @(negedge clk_i);
    check("R8 dout", dout_o, 16'h0);
    check("R8 valid", valid_o, 1'b0);
    valid_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int k = 0; k < NVEC; k++) begin
      apply(1'b1, VEC[k][35:34], VEC[k][33:16]);
      check($sformatf("R1-4 vec%0d dout", k), dout_o, VEC[k][15:0]);
      check("R6 valid", valid_o, 1'b1);
    end

    // R6 latency: new word not visible before the edge
    valid_i = 1'b1; sel_i = 2'b00; din_i = 18'h01234;
    #1 check("R6 before edge", dout_o, 16'h3FFF);
    @(negedge clk_i);
    check("R6 after edge", dout_o, 16'h1234);

    // R7 hold while invalid
    apply(1'b0, 2'b10, 18'h3FFFF);
    check("R7 hold dout", dout_o, 16'h1234);
    check("R7 valid low", valid_o, 1'b0);
    apply(1'b0, 2'b01, 18'h00000);
    check("R7 hold dout 2", dout_o, 16'h1234);

    // R5 carried bits only reach bits 14/15
    apply(1'b1, 2'b10, 18'h2FFFF);
    check("R5 edge", dout_o, 16'h3FFF);
    apply(1'b1, 2'b10, 18'h3BFFF);
    check("R5 interior", dout_o, 16'hBFFF & 16'hDFFF & 16'hEFFF);

    // R9 density over PRBS-15
    density_run(2'b00, 500, "R9 half");
    density_run(2'b01, 250, "R9 quarter");
    density_run(2'b10, 125, "R9 eighth");

    // R8 asynchronous reset mid-run
    apply(1'b1, 2'b00, 18'h0FFFF);
    rst_ni = 1'b0;
    #1 check("R8 async dout", dout_o, 16'h0);
    check("R8 async valid", valid_o, 1'b0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule